// File: doc/BRIEF.md
# Flash Program/Erase Guard

This block sits between software and a flash array and decides whether a program or erase pulse may start. Software selects an operation through a small control register, names the target location by writing to the array, reads the protection register, and then asks for the high-voltage enable. The block grants that request only when this sequence was followed and the target lies outside the locked area. A granted pulse ends when the array reports completion.

The locked area is set by a one-byte protect value. The byte is stored in the array itself and behaves like any other flash cell: a program can only clear its bits, and an erase sets it back to all ones. The byte turns into a starting address with 256-byte granularity, and the locked area runs from there to the top address. A test-voltage input lifts every protection rule for as long as it is high.

Top module: `flash_guard`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x00, `hv_on` and `tgt_addr` are 0, and the protect register reads the power-up value 0xFF.
- R2: A control write with both the program bit (bit 0) and the erase bit (bit 1) set is ignored as a whole. It does not change the control register, does not count as an enable attempt, and does not raise the violation flag.
- R3: A protect byte P other than 0xFF locks addresses from {P, 0x00} up to 0xFFFF inclusive. P = 0x00 locks everything and P = 0xFF locks nothing. An enable attempt whose target is locked leaves `hv_on` at 0.
- R4: An enable attempt (a control write with bit 3 set while `hv_on` is 0) succeeds only if the mode is armed and unchanged by that write, and only if, since arming, the protect register (select 1) was read and the target address was latched. A read made before arming does not count.
- R5: A refused attempt raises the sticky violation flag (status bit 0). Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R6: While `tst_volt` is high at the attempt, every protection rule (R3, R7) is bypassed. The ordering rule R4 still applies.
- R7: While P is not 0xFF, these are refused: a program aimed at the protect byte's own location (`PROT_ADDR`, default 0xFD7E), a page erase of the 64-byte page holding it, and any mass erase (erase with bit 2 set).
- R8: A completion (`op_done` while `hv_on` is 1) of a program aimed at `PROT_ADDR` ANDs the latched data into P. A program completing at any other address leaves P unchanged.
- R9: A completion of a mass erase, or of a page erase covering `PROT_ADDR`, sets P to 0xFF.
- R10: An array write latches its address into `tgt_addr` only while the mode is armed and `hv_on` is 0. At any other time `tgt_addr` is unchanged.
- R11: A legal control write that changes the program, erase or mass bits clears `hv_on` and discards the read and address progress of R4. A control write with bit 3 clear also clears `hv_on`.
- R12: Register reads are combinational. Select 0 gives {0000, enable, mass, erase, program}, select 1 gives P, select 2 gives {0000000, violation}, and select 3 gives 0. Writes to select 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 protect, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| arr_wr | input | 1 | Write to the flash array space |
| arr_addr | input | 16 | Array write address |
| arr_wdata | input | 8 | Array write data |
| tst_volt | input | 1 | Test-voltage present; bypasses protection |
| op_done | input | 1 | Array reports the high-voltage pulse finished |
| hv_on | output | 1 | High-voltage enable granted |
| op_prog | output | 1 | Program mode selected |
| op_erase | output | 1 | Erase mode selected |
| op_mass | output | 1 | Mass erase selected |
| tgt_addr | output | 16 | Latched target address |

## Verification
Register and array writes are sampled on one rising edge, and their effects on `hv_on`, `tgt_addr`, the mode outputs and the violation flag show after that same edge. The bench therefore compares them at the falling edge that follows. `reg_rdata` is combinational and is checked in the same cycle as its select. A change to the protect byte shows one edge after the `op_done` cycle. A reference model updated on each rising edge from the inputs alone is compared against every output at every falling edge. Directed checks with hand-computed values cover the address window boundary, the self-lock, the bypass and the ordering rule.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

   // Control register layout, bit 3 down to bit 0
   typedef struct packed {
      logic hv;
      logic mass;
      logic ers;
      logic pgm;
   } fg_ctrl_t;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_PROT = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } fg_sel_e;

endpackage

// File: rtl/fg_window.sv
// Protection decision: address window, self-lock, mass lock, bypass.
module fg_window #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PROT_W    = 8,
   parameter int unsigned PAGE_BITS = 6,
   parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFD7E
) (
   input  logic [PROT_W-1:0] prot_byte,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              is_prog,
   input  logic              is_erase,
   input  logic              is_mass,
   input  logic              bypass,
   output logic              in_region,
   output logic              blocked
);
   localparam int unsigned LOW_W = ADDR_W - PROT_W;

   logic [ADDR_W-1:0] start_addr;
   logic              active;
   logic              page_hit;
   logic              self_hit;
   logic              mass_hit;

   generate
      if (PROT_W > ADDR_W) begin : g_bad_width
         $error("fg_window: PROT_W wider than ADDR_W");
      end
      if (PAGE_BITS > LOW_W) begin : g_bad_page
         $error("fg_window: page larger than protection granule");
      end
      if (LOW_W == 0) begin : g_full
         assign start_addr = prot_byte;
      end else begin : g_pad
         assign start_addr = {prot_byte, {LOW_W{1'b0}}};
      end
   endgenerate

   assign active    = ~&prot_byte;
   assign in_region = active && (tgt_addr >= start_addr);
   assign page_hit  = tgt_addr[ADDR_W-1:PAGE_BITS] == PROT_ADDR[ADDR_W-1:PAGE_BITS];
   assign self_hit  = active && ((is_prog && (tgt_addr == PROT_ADDR)) ||
                                 (is_erase && !is_mass && page_hit));
   assign mass_hit  = active && is_erase && is_mass;
   assign blocked   = !bypass && (in_region || self_hit || mass_hit);

endmodule

// File: rtl/fg_seq.sv
// Control bits, access-order tracking, enable grant and violation flag.
module fg_seq
   import flash_guard_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ctrl_wr,
   input  fg_ctrl_t ctrl_wd,
   input  logic     prot_rd,
   input  logic     arr_wr,
   input  logic     blocked,
   input  logic     viol_clr,
   output fg_ctrl_t ctrl_q,
   output logic     viol_q,
   output logic     latch_en
);
   logic rd_seen_q;
   logic ad_seen_q;
   logic armed;
   logic legal;
   logic mode_chg;
   logic attempt;
   logic grant;

   assign armed    = ctrl_q.pgm || ctrl_q.ers;
   assign legal    = ctrl_wr && !(ctrl_wd.pgm && ctrl_wd.ers);
   assign mode_chg = legal && ({ctrl_wd.mass, ctrl_wd.ers, ctrl_wd.pgm} !=
                               {ctrl_q.mass, ctrl_q.ers, ctrl_q.pgm});
   assign attempt  = legal && ctrl_wd.hv && !ctrl_q.hv;
   assign grant    = attempt && !mode_chg && armed && rd_seen_q && ad_seen_q && !blocked;
   assign latch_en = arr_wr && armed && !ctrl_q.hv;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         viol_q    <= 1'b0;
         rd_seen_q <= 1'b0;
         ad_seen_q <= 1'b0;
      end else begin
         if (legal) begin
            ctrl_q.pgm  <= ctrl_wd.pgm;
            ctrl_q.ers  <= ctrl_wd.ers;
            ctrl_q.mass <= ctrl_wd.mass;
            if (attempt)
               ctrl_q.hv <= grant;
            else if (mode_chg || !ctrl_wd.hv)
               ctrl_q.hv <= 1'b0;
         end
         if (attempt && !grant)
            viol_q <= 1'b1;
         else if (viol_clr)
            viol_q <= 1'b0;
         if (mode_chg)
            rd_seen_q <= 1'b0;
         else if (prot_rd && armed)
            rd_seen_q <= 1'b1;
         if (mode_chg)
            ad_seen_q <= 1'b0;
         else if (latch_en)
            ad_seen_q <= 1'b1;
      end
   end

   assert_hv_needs_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.hv |-> (rd_seen_q && ad_seen_q && armed));
   assert_refusal_raises_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (attempt && !grant) |=> viol_q);
   assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_q && !viol_clr) |=> viol_q);
   assert_both_modes_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && ctrl_wd.pgm && ctrl_wd.ers) |=> $stable(ctrl_q));

endmodule

// File: rtl/fg_protbyte.sv
// Non-volatile protect byte modelled as a flash cell.
module fg_protbyte #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PROT_W    = 8,
   parameter int unsigned PAGE_BITS = 6,
   parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFD7E,
   parameter logic [PROT_W-1:0] PROT_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              is_prog,
   input  logic              is_erase,
   input  logic              is_mass,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [PROT_W-1:0] tgt_data,
   output logic [PROT_W-1:0] prot_q
);
   logic hit_prog;
   logic hit_wipe;

   assign hit_prog = done && is_prog && (tgt_addr == PROT_ADDR);
   assign hit_wipe = done && is_erase &&
                     (is_mass || (tgt_addr[ADDR_W-1:PAGE_BITS] == PROT_ADDR[ADDR_W-1:PAGE_BITS]));

   always_ff @(posedge clk) begin
      if (!rst_n)
         prot_q <= PROT_INIT;
      else if (hit_wipe)
         prot_q <= '1;
      else if (hit_prog)
         prot_q <= prot_q & tgt_data;
   end

   assert_prog_only_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((prot_q & ~$past(prot_q)) != '0) |-> $past(hit_wipe));
   assert_wipe_sets_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit_wipe |=> (&prot_q));

endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import flash_guard_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned PROT_W    = 8,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned PAGE_BITS = 6,
   parameter logic [ADDR_W-1:0] PROT_ADDR = 16'hFD7E,
   parameter logic [PROT_W-1:0] PROT_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              arr_wr,
   input  logic [ADDR_W-1:0] arr_addr,
   input  logic [PROT_W-1:0] arr_wdata,
   input  logic              tst_volt,
   input  logic              op_done,
   output logic              hv_on,
   output logic              op_prog,
   output logic              op_erase,
   output logic              op_mass,
   output logic [ADDR_W-1:0] tgt_addr
);
   generate
      if (REG_W < 4 || REG_W < PROT_W) begin : g_bad_reg
         $error("flash_guard: REG_W too narrow");
      end
   endgenerate

   fg_ctrl_t          ctrl_q;
   fg_ctrl_t          ctrl_wd;
   logic              viol_q;
   logic              latch_en;
   logic              blocked;
   logic              in_region;
   logic [PROT_W-1:0] prot_q;
   logic [ADDR_W-1:0] tgt_q;
   logic [PROT_W-1:0] dat_q;
   logic              ctrl_wr;
   logic              viol_clr;
   logic              prot_rd;
   logic              unused_wbits;

   assign ctrl_wr      = reg_wr && (reg_sel == SEL_CTRL);
   assign viol_clr     = reg_wr && (reg_sel == SEL_STAT) && reg_wdata[0];
   assign prot_rd      = reg_rd && (reg_sel == SEL_PROT);
   assign ctrl_wd      = fg_ctrl_t'(reg_wdata[3:0]);
   assign unused_wbits = ^reg_wdata[REG_W-1:4];

   fg_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (ctrl_wr),
      .ctrl_wd  (ctrl_wd),
      .prot_rd  (prot_rd),
      .arr_wr   (arr_wr),
      .blocked  (blocked),
      .viol_clr (viol_clr),
      .ctrl_q   (ctrl_q),
      .viol_q   (viol_q),
      .latch_en (latch_en)
   );

   fg_window #(
      .ADDR_W(ADDR_W), .PROT_W(PROT_W), .PAGE_BITS(PAGE_BITS), .PROT_ADDR(PROT_ADDR)
   ) u_window (
      .prot_byte (prot_q),
      .tgt_addr  (tgt_q),
      .is_prog   (ctrl_q.pgm),
      .is_erase  (ctrl_q.ers),
      .is_mass   (ctrl_q.mass),
      .bypass    (tst_volt),
      .in_region (in_region),
      .blocked   (blocked)
   );

   fg_protbyte #(
      .ADDR_W(ADDR_W), .PROT_W(PROT_W), .PAGE_BITS(PAGE_BITS),
      .PROT_ADDR(PROT_ADDR), .PROT_INIT(PROT_INIT)
   ) u_prot (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (op_done && ctrl_q.hv),
      .is_prog  (ctrl_q.pgm),
      .is_erase (ctrl_q.ers),
      .is_mass  (ctrl_q.mass),
      .tgt_addr (tgt_q),
      .tgt_data (dat_q),
      .prot_q   (prot_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q <= '0;
         dat_q <= '0;
      end else if (latch_en) begin
         tgt_q <= arr_addr;
         dat_q <= arr_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel)
         SEL_CTRL: reg_rdata[3:0]        = ctrl_q;
         SEL_PROT: reg_rdata[PROT_W-1:0] = prot_q;
         SEL_STAT: reg_rdata[0]          = viol_q;
         default:  reg_rdata             = '0;
      endcase
   end

   assign hv_on    = ctrl_q.hv;
   assign op_prog  = ctrl_q.pgm;
   assign op_erase = ctrl_q.ers;
   assign op_mass  = ctrl_q.ers && ctrl_q.mass;
   assign tgt_addr = tgt_q;

   assert_no_hv_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hv_on) |-> ($past(tst_volt) || !$past(in_region)));
   assert_tgt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!latch_en) |=> $stable(tgt_q));

endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;
   localparam logic [15:0] PA = 16'hFD7E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        arr_wr = 1'b0;
   logic [15:0] arr_addr = 16'h0;
   logic [7:0]  arr_wdata = 8'h00;
   logic        tst_volt = 1'b0, op_done = 1'b0;
   logic        hv_on, op_prog, op_erase, op_mass;
   logic [15:0] tgt_addr;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   flash_guard #(.PROT_ADDR(PA)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_wr(arr_wr), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .tst_volt(tst_volt), .op_done(op_done), .hv_on(hv_on),
      .op_prog(op_prog), .op_erase(op_erase), .op_mass(op_mass), .tgt_addr(tgt_addr)
   );

   // ---------------- reference model ----------------
   bit        m_pgm, m_ers, m_mass, m_hv, m_viol, m_rd, m_ad;
   bit [7:0]  m_prot = 8'hFF;
   bit [15:0] m_tgt;
   bit [7:0]  m_dat;

   function automatic bit refused(input bit [15:0] a, input bit pg, input bit er,
                                  input bit ms, input bit by, input bit [7:0] p);
      bit locked;
      bit hit;
      locked = (p != 8'hFF);
      hit = locked && (a >= {p, 8'h00});
      if (locked && pg && a == PA) hit = 1'b1;
      if (locked && er && ms) hit = 1'b1;
      if (locked && er && !ms && a[15:6] == PA[15:6]) hit = 1'b1;
      return hit && !by;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pgm = 0; m_ers = 0; m_mass = 0; m_hv = 0; m_viol = 0; m_rd = 0; m_ad = 0;
         m_prot = 8'hFF; m_tgt = 0; m_dat = 0;
      end else begin
         bit armed, chg, att, ok, n_hv, n_viol, n_rd, n_ad;
         bit [7:0] n_prot;
         armed = m_pgm || m_ers;
         n_hv = m_hv; n_viol = m_viol; n_rd = m_rd; n_ad = m_ad; n_prot = m_prot;
         if (op_done && m_hv) begin
            if (m_pgm && m_tgt == PA) n_prot = m_prot & m_dat;
            if (m_ers && (m_mass || m_tgt[15:6] == PA[15:6])) n_prot = 8'hFF;
         end
         if (reg_rd && reg_sel == 2'd1 && armed) n_rd = 1;
         if (arr_wr && armed && !m_hv) begin
            n_ad = 1; m_tgt = arr_addr; m_dat = arr_wdata;
         end
         if (reg_wr && reg_sel == 2'd2 && reg_wdata[0]) n_viol = 0;
         if (reg_wr && reg_sel == 2'd0 && !(reg_wdata[0] && reg_wdata[1])) begin
            chg = {reg_wdata[2], reg_wdata[1], reg_wdata[0]} != {m_mass, m_ers, m_pgm};
            att = reg_wdata[3] && !m_hv;
            if (att) begin
               ok = !chg && armed && m_rd && m_ad &&
                    !refused(m_tgt, m_pgm, m_ers, m_mass, tst_volt, m_prot);
               n_hv = ok;
               if (!ok) n_viol = 1;
            end else if (chg || !reg_wdata[3]) n_hv = 0;
            if (chg) begin n_rd = 0; n_ad = 0; end
            m_pgm = reg_wdata[0]; m_ers = reg_wdata[1]; m_mass = reg_wdata[2];
         end
         m_hv = n_hv; m_viol = n_viol; m_rd = n_rd; m_ad = n_ad; m_prot = n_prot;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [7:0] exp_rd;
         case (reg_sel)
            2'd0: exp_rd = {4'b0, m_hv, m_mass, m_ers, m_pgm};
            2'd1: exp_rd = m_prot;
            2'd2: exp_rd = {7'b0, m_viol};
            default: exp_rd = 8'h00;
         endcase
         chk("R4 cycle hv_on", hv_on, m_hv);
         chk("R10 cycle tgt_addr", tgt_addr, m_tgt);
         chk("R11 cycle mode outputs", {op_prog, op_erase, op_mass}, {m_pgm, m_ers, m_ers & m_mass});
         chk("R12 cycle reg_rdata", reg_rdata, exp_rd);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(posedge clk); #1;
      reg_wr = 1; reg_sel = s; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 0; reg_wdata = 8'h00;
   endtask

   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      @(posedge clk); #1;
      reg_rd = 1; reg_sel = s;
      @(negedge clk); v = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 0;
   endtask

   task automatic awr(input logic [15:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      arr_wr = 1; arr_addr = a; arr_wdata = d;
      @(posedge clk); #1;
      arr_wr = 0;
   endtask

   task automatic done_pulse();
      @(posedge clk); #1; op_done = 1;
      @(posedge clk); #1; op_done = 0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      settle();
      chk("R1 hv after reset", hv_on, 0);
      chk("R1 tgt after reset", tgt_addr, 16'h0000);
      rd(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
      rd(2'd1, v); chk("R1 protect reset", v, 8'hFF);
      rd(2'd2, v); chk("R1 status reset", v, 8'h00);

      wr(2'd1, 8'h00); rd(2'd1, v); chk("R12 protect write ignored", v, 8'hFF);
      rd(2'd3, v); chk("R12 select 3 reads zero", v, 8'h00);

      // ordinary program, no effect on protect byte
      wr(2'd0, 8'h01); rd(2'd1, v); awr(16'h1234, 8'h55); wr(2'd0, 8'h09); settle();
      chk("R4 granted after full order", hv_on, 1);
      chk("R10 target latched", tgt_addr, 16'h1234);
      awr(16'h0101, 8'h00); settle();
      chk("R10 no latch while enabled", tgt_addr, 16'h1234);
      done_pulse(); rd(2'd1, v); chk("R8 other address leaves byte", v, 8'hFF);
      wr(2'd0, 8'h00); settle(); chk("R11 disarm clears enable", hv_on, 0);

      // program protect byte to 0xFE
      wr(2'd0, 8'h01); rd(2'd1, v); awr(PA, 8'hFE); wr(2'd0, 8'h09); done_pulse();
      wr(2'd0, 8'h00); rd(2'd1, v); chk("R8 protect byte programmed", v, 8'hFE);

      // window boundary
      wr(2'd0, 8'h01); rd(2'd1, v); awr(16'hFE00, 8'hAA); wr(2'd0, 8'h09); settle();
      chk("R3 window start refused", hv_on, 0);
      rd(2'd2, v); chk("R5 flag raised", v, 8'h01);
      wr(2'd2, 8'h00); rd(2'd2, v); chk("R5 write 0 keeps flag", v, 8'h01);
      wr(2'd2, 8'h01); rd(2'd2, v); chk("R5 write 1 clears flag", v, 8'h00);
      awr(16'hFDFF, 8'hAA); wr(2'd0, 8'h09); settle();
      chk("R3 just below window granted", hv_on, 1);
      awr(16'h4444, 8'h00); settle(); chk("R10 enabled ignores array write", tgt_addr, 16'hFDFF);
      wr(2'd0, 8'h00); awr(16'h2222, 8'h00); settle();
      chk("R10 unarmed ignores array write", tgt_addr, 16'hFDFF);

      // self-lock and mass lock
      wr(2'd0, 8'h01); rd(2'd1, v); awr(PA, 8'h00); wr(2'd0, 8'h09); settle();
      chk("R7 program of protect byte refused", hv_on, 0);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h02); rd(2'd1, v); awr(16'hFD50, 8'h00); wr(2'd0, 8'h0A); settle();
      chk("R7 page erase of protect page refused", hv_on, 0);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h06); rd(2'd1, v); awr(16'h0000, 8'h00); wr(2'd0, 8'h0E); settle();
      chk("R7 mass erase refused", hv_on, 0);
      wr(2'd2, 8'h01); wr(2'd0, 8'h00);

      // ordering
      rd(2'd1, v); wr(2'd0, 8'h01); awr(16'h1000, 8'h00); wr(2'd0, 8'h09); settle();
      chk("R4 read before arming does not count", hv_on, 0);
      wr(2'd2, 8'h01); rd(2'd1, v); wr(2'd0, 8'h09); settle();
      chk("R4 read after arming enables", hv_on, 1);
      wr(2'd0, 8'h00);

      // both mode bits
      wr(2'd0, 8'h01); wr(2'd0, 8'h03); rd(2'd0, v); chk("R2 both bits ignored", v, 8'h01);
      wr(2'd0, 8'h0B); rd(2'd0, v); chk("R2 both bits with enable ignored", v, 8'h01);
      rd(2'd2, v); chk("R2 no violation from ignored write", v, 8'h00);
      wr(2'd0, 8'h00);

      // mode change discards progress
      wr(2'd0, 8'h01); rd(2'd1, v); awr(16'h1000, 8'h00); wr(2'd0, 8'h02); wr(2'd0, 8'h0A); settle();
      chk("R11 mode change restarts order", hv_on, 0);
      wr(2'd2, 8'h01); wr(2'd0, 8'h00);

      // bypass mass erase
      tst_volt = 1;
      wr(2'd0, 8'h06); rd(2'd1, v); awr(16'hFF00, 8'h00); wr(2'd0, 8'h0E); settle();
      chk("R6 bypass grants mass erase", hv_on, 1);
      done_pulse(); rd(2'd1, v); chk("R9 mass erase restores byte", v, 8'hFF);
      wr(2'd0, 8'h00); tst_volt = 0;

      // lock everything
      wr(2'd0, 8'h01); rd(2'd1, v); awr(PA, 8'h00); wr(2'd0, 8'h09); done_pulse();
      wr(2'd0, 8'h00); rd(2'd1, v); chk("R8 protect byte to zero", v, 8'h00);
      wr(2'd0, 8'h01); rd(2'd1, v); awr(16'h0000, 8'h00); wr(2'd0, 8'h09); settle();
      chk("R3 zero byte locks address 0", hv_on, 0);
      wr(2'd2, 8'h01); tst_volt = 1; wr(2'd0, 8'h09); settle();
      chk("R6 bypass opens locked address", hv_on, 1);
      done_pulse(); wr(2'd0, 8'h00);
      wr(2'd0, 8'h02); rd(2'd1, v); awr(16'hFD50, 8'h00); wr(2'd0, 8'h0A); done_pulse();
      wr(2'd0, 8'h00); tst_volt = 0;
      rd(2'd1, v); chk("R9 page erase restores byte", v, 8'hFF);

      repeat (3) @(posedge clk);
      finished = 1;
      summary();
      $finish;
   end

endmodule